// File: doc/BRIEF.md
# Doorbell Transmit Queue Sequencer

This block sends outbound messages to a peer through a mailbox: a payload region of up to 128 bytes plus one doorbell word. Writing the doorbell hands the message to the peer. The peer later raises a busy-clear event to say it has consumed the message. A local producer offers one message at a time, as a doorbell word and a payload vector, on a valid/ready port.

If the channel is idle, the message goes out at once. The payload is written in 32-bit words, any trailing bytes follow as single-byte writes, and the doorbell word is written last. If the channel is busy, the message is held in a small in-order queue. Each busy-clear event launches the oldest held message, or marks the channel idle when nothing is held. Every busy-clear event is acknowledged on a separate output once it has been dealt with.

A message whose length field exceeds the payload capacity is rejected, with an oversize error. A message offered while the queue is full is also rejected, with a queue-full error. Neither case stalls the producer.

Top module: `dbell_txq`

## Requirements
- R1: Synchronous active-high reset. After reset the channel is idle, `sub_ready` is high, and `mb_we`, `err_valid` and `clr_ack` are low.
- R2: A message accepted while the channel is idle is written out without waiting for any busy-clear event. All of its payload writes come before one final write with `mb_doorbell`=1, whose data is the accepted doorbell word unchanged and whose `mb_addr` is 0.
- R3: The payload length is bits [9:0] of the doorbell word. Payload goes out as full words (`mb_be`=4'hF, `mb_addr` = byte offset, a multiple of 4, data = payload bytes offset..offset+3 with the lowest-offset byte in bits [7:0]). After the full words come the last 1 to 3 bytes, one write each, each with `mb_be` one-hot at lane `mb_addr[1:0]` and the byte copied into all four data lanes.
- R4: A message whose length field is above 128 is not written. It produces `err_code`=1 (oversize), and the channel state is left unchanged.
- R5: While the channel is busy, accepted messages are held. Up to 8 can be held besides the one in flight, with no error.
- R6: A message offered while busy with 8 held is dropped with `err_code`=2 (queue full). It is never written to the mailbox.
- R7: Each busy-clear event with messages held launches the oldest one, so messages reach the mailbox in acceptance order.
- R8: A busy-clear event with nothing held makes the channel idle, and the next accepted message is written out at once.
- R9: `clr_ack` pulses for one cycle per busy-clear event. The pulse comes right after the launched message's doorbell write, or right away when nothing was held.
- R10: `sub_ready` is low in any cycle in which `clr_evt` is high. A message offered in that cycle is taken only after the busy-clear event has been processed, so a clear arriving at a full queue frees a slot for it.
- R11: A message of length 0 produces exactly one mailbox write, the doorbell.
- R12: `err_valid` is a single-cycle pulse per rejected message, the cycle after acceptance. `err_code` is 1 or 2 whenever it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_valid | input | 1 | Producer offers a message |
| sub_ready | output | 1 | Block takes the offered message at this edge |
| sub_db | input | 32 | Doorbell word; bits [9:0] are the payload length |
| sub_payload | input | 1024 | Payload, byte i in bits [8i+7:8i] |
| mb_we | output | 1 | Mailbox write strobe |
| mb_doorbell | output | 1 | This write targets the doorbell word |
| mb_addr | output | 7 | Byte offset within the payload region |
| mb_wdata | output | 32 | Write data |
| mb_be | output | 4 | Byte lane enables |
| clr_evt | input | 1 | Peer busy-clear event, one cycle per event |
| clr_ack | output | 1 | Busy-clear event handled |
| err_valid | output | 1 | A message was rejected |
| err_code | output | 2 | 1 = oversize, 2 = queue full |

## Verification
The checks assume the peer raises a busy-clear event only once for each doorbell it has seen, and never during reset. They also assume the producer keeps `sub_db` and `sub_payload` steady while `sub_valid` is high. The stimulus therefore pulses `clr_evt` for one cycle, and only after the matching doorbell write has appeared. It changes message fields only on the falling edge, and only once a message has been taken. The one overlap the bench deliberately creates is a submit raised in the same cycle as a busy-clear. This tests the ordering rule while the queue is full.

// File: rtl/dbell_txq_pkg.sv
package dbell_txq_pkg;
  localparam int WORD_W   = 32;
  localparam int LEN_BITS = 10;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_OVERSIZE = 2'd1,
    ERR_QFULL   = 2'd2
  } txq_err_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_XFER
  } txq_state_e;
endpackage

// File: rtl/dbell_txq_store.sv
module dbell_txq_store #(
  parameter int DEPTH = 8,
  parameter int PAY_W = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                             clk,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [dbell_txq_pkg::WORD_W-1:0] wr_db,
  input  logic [PAY_W-1:0]                 wr_pay,
  input  logic                             rd_en,
  input  logic [IDX_W-1:0]                 rd_idx,
  output logic [dbell_txq_pkg::WORD_W-1:0] rd_db,
  output logic [PAY_W-1:0]                 rd_pay
);
  logic [PAY_W-1:0]                 pay_mem [DEPTH];
  logic [dbell_txq_pkg::WORD_W-1:0] db_mem  [DEPTH];

  // Plain synchronous RAM: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      pay_mem[wr_idx] <= wr_pay;
      db_mem[wr_idx]  <= wr_db;
    end
    if (rd_en) begin
      rd_pay <= pay_mem[rd_idx];
      rd_db  <= db_mem[rd_idx];
    end
  end
endmodule

// File: rtl/dbell_txq_emit.sv
module dbell_txq_emit #(
  parameter int MAX_BYTES = 128,
  localparam int PAY_W  = MAX_BYTES * 8,
  localparam int OFS_W  = $clog2(MAX_BYTES + 1),
  localparam int ADDR_W = $clog2(MAX_BYTES)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  logic [dbell_txq_pkg::WORD_W-1:0] db,
  input  logic [PAY_W-1:0]                 payload,
  output logic                             mb_we,
  output logic                             mb_doorbell,
  output logic [ADDR_W-1:0]                mb_addr,
  output logic [dbell_txq_pkg::WORD_W-1:0] mb_wdata,
  output logic [3:0]                       mb_be,
  output logic                             done
);
  logic             active;
  logic [OFS_W-1:0] ofs;
  logic [OFS_W-1:0] len;
  logic [OFS_W-1:0] remaining;
  logic [31:0]      cur_word;
  logic [7:0]       cur_byte;

  assign len       = db[OFS_W-1:0];
  assign remaining = len - ofs;
  assign cur_word  = payload[{ofs, 3'b000} +: 32];
  assign cur_byte  = payload[{ofs, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b0;
      ofs         <= '0;
      mb_we       <= 1'b0;
      mb_doorbell <= 1'b0;
      mb_addr     <= '0;
      mb_wdata    <= '0;
      mb_be       <= '0;
      done        <= 1'b0;
    end else begin
      mb_we       <= 1'b0;
      mb_doorbell <= 1'b0;
      done        <= 1'b0;
      if (start) begin
        active <= 1'b1;
        ofs    <= '0;
      end else if (active) begin
        mb_we   <= 1'b1;
        mb_addr <= ofs[ADDR_W-1:0];
        if (remaining >= OFS_W'(4)) begin
          mb_wdata <= cur_word;
          mb_be    <= 4'hF;
          ofs      <= ofs + OFS_W'(4);
        end else if (remaining != '0) begin
          mb_wdata <= {4{cur_byte}};
          mb_be    <= 4'b0001 << ofs[1:0];
          ofs      <= ofs + OFS_W'(1);
        end else begin
          // Doorbell goes last: it hands the message to the peer.
          mb_doorbell <= 1'b1;
          mb_addr     <= '0;
          mb_wdata    <= db;
          mb_be       <= 4'hF;
          active      <= 1'b0;
          done        <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dbell_txq.sv
module dbell_txq #(
  parameter int MAX_BYTES = 128,
  parameter int DEPTH     = 8,
  localparam int PAY_W  = MAX_BYTES * 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ADDR_W = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sub_valid,
  output logic              sub_ready,
  input  logic [31:0]       sub_db,
  input  logic [PAY_W-1:0]  sub_payload,
  output logic              mb_we,
  output logic              mb_doorbell,
  output logic [ADDR_W-1:0] mb_addr,
  output logic [31:0]       mb_wdata,
  output logic [3:0]        mb_be,
  input  logic              clr_evt,
  output logic              clr_ack,
  output logic              err_valid,
  output logic [1:0]        err_code
);
  import dbell_txq_pkg::*;

  txq_state_e       state;
  logic             busy;
  logic             clr_pend;
  logic             ack_due;
  logic             kick;
  logic [IDX_W-1:0] head;
  logic [IDX_W-1:0] tail;
  logic [IDX_W-1:0] send_idx;
  logic [CNT_W-1:0] count;

  logic [WORD_W-1:0] rd_db;
  logic [PAY_W-1:0]  rd_pay;
  logic              emit_done;

  logic len_bad;
  logic q_full;
  logic handle_clr;
  logic accept;
  logic store_wr;

  assign len_bad    = sub_db[LEN_BITS-1:0] > LEN_BITS'(MAX_BYTES);
  assign q_full     = (count == CNT_W'(DEPTH));
  assign handle_clr = (state == ST_IDLE) && clr_pend;
  // A busy-clear in this cycle or still pending takes precedence over a submit.
  assign sub_ready  = (state == ST_IDLE) && !clr_pend && !clr_evt;
  assign accept     = sub_valid && sub_ready;
  assign store_wr   = accept && !len_bad && !(busy && q_full);

  dbell_txq_store #(.DEPTH(DEPTH), .PAY_W(PAY_W)) u_store (
    .clk    (clk),
    .wr_en  (store_wr),
    .wr_idx (tail),
    .wr_db  (sub_db),
    .wr_pay (sub_payload),
    .rd_en  (state == ST_LOAD),
    .rd_idx (send_idx),
    .rd_db  (rd_db),
    .rd_pay (rd_pay)
  );

  dbell_txq_emit #(.MAX_BYTES(MAX_BYTES)) u_emit (
    .clk         (clk),
    .rst         (rst),
    .start       (kick),
    .db          (rd_db),
    .payload     (rd_pay),
    .mb_we       (mb_we),
    .mb_doorbell (mb_doorbell),
    .mb_addr     (mb_addr),
    .mb_wdata    (mb_wdata),
    .mb_be       (mb_be),
    .done        (emit_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      clr_pend  <= 1'b0;
      ack_due   <= 1'b0;
      kick      <= 1'b0;
      head      <= '0;
      tail      <= '0;
      send_idx  <= '0;
      count     <= '0;
      clr_ack   <= 1'b0;
      err_valid <= 1'b0;
      err_code  <= ERR_NONE;
    end else begin
      err_valid <= 1'b0;
      clr_ack   <= 1'b0;
      kick      <= (state == ST_LOAD);
      if (clr_evt)         clr_pend <= 1'b1;
      else if (handle_clr) clr_pend <= 1'b0;

      case (state)
        ST_IDLE: begin
          if (handle_clr) begin
            if (count != '0) begin
              send_idx <= head;
              head     <= head + IDX_W'(1);
              count    <= count - CNT_W'(1);
              ack_due  <= 1'b1;
              state    <= ST_LOAD;
            end else begin
              busy    <= 1'b0;
              clr_ack <= 1'b1;
            end
          end else if (accept) begin
            if (len_bad) begin
              err_valid <= 1'b1;
              err_code  <= ERR_OVERSIZE;
            end else if (busy && q_full) begin
              err_valid <= 1'b1;
              err_code  <= ERR_QFULL;
            end else if (busy) begin
              tail  <= tail + IDX_W'(1);
              count <= count + CNT_W'(1);
            end else begin
              // Idle channel: the entry passes through the store and leaves at once.
              tail     <= tail + IDX_W'(1);
              head     <= head + IDX_W'(1);
              send_idx <= tail;
              busy     <= 1'b1;
              ack_due  <= 1'b0;
              state    <= ST_LOAD;
            end
          end
        end
        ST_LOAD: state <= ST_XFER;
        ST_XFER: begin
          if (emit_done) begin
            state   <= ST_IDLE;
            clr_ack <= ack_due;
            ack_due <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbell_txq_chk.sv
module dbell_txq_chk #(
  parameter int MAX_BYTES = 128
) (
  input logic       clk,
  input logic       rst,
  input logic       sub_ready,
  input logic       clr_evt,
  input logic       mb_we,
  input logic       mb_doorbell,
  input logic [1:0] mb_addr_lo,
  input logic [3:0] mb_be,
  input logic [9:0] db_len,
  input logic       clr_ack,
  input logic       err_valid,
  input logic [1:0] err_code
);
  // R1: first cycle out of reset is quiet
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!mb_we && !err_valid && !clr_ack));

  // R2: the doorbell write closes a message burst
  p_db_last_r2: assert property (@(posedge clk) disable iff (rst)
    (mb_we && mb_doorbell) |=> !mb_we);

  // R3: payload writes are a full word on an aligned offset or one byte on its lane
  p_lane_r3: assert property (@(posedge clk) disable iff (rst)
    (mb_we && !mb_doorbell) |->
      (($countones(mb_be) == 4 && mb_addr_lo == 2'd0) ||
       ($countones(mb_be) == 1 && mb_be == (4'b0001 << mb_addr_lo))));

  // R3: once trailing bytes start, no full word follows in that message
  p_word_before_byte_r3: assert property (@(posedge clk) disable iff (rst)
    (mb_we && !mb_doorbell && $countones(mb_be) == 1) |=>
      !(mb_we && !mb_doorbell && $countones(mb_be) == 4));

  // R4: no doorbell carrying an oversize length ever reaches the mailbox
  p_len_cap_r4: assert property (@(posedge clk) disable iff (rst)
    (mb_we && mb_doorbell) |-> (db_len <= 10'(MAX_BYTES)));

  // R9: one acknowledge pulse per event
  p_ack_single_r9: assert property (@(posedge clk) disable iff (rst)
    clr_ack |=> !clr_ack);

  // R10: a busy-clear in the cycle blocks the submit port
  p_ready_yields_r10: assert property (@(posedge clk) disable iff (rst)
    clr_evt |-> !sub_ready);

  // R12: an error always carries a defined code
  p_err_code_r12: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> (err_code == 2'd1 || err_code == 2'd2));
endmodule

bind dbell_txq dbell_txq_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sub_ready   (sub_ready),
  .clr_evt     (clr_evt),
  .mb_we       (mb_we),
  .mb_doorbell (mb_doorbell),
  .mb_addr_lo  (mb_addr[1:0]),
  .mb_be       (mb_be),
  .db_len      (mb_wdata[9:0]),
  .clr_ack     (clr_ack),
  .err_valid   (err_valid),
  .err_code    (err_code)
);

// File: tb/dbell_txq_tb.sv
module dbell_txq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 128;
  localparam int PW   = NB * 8;
  localparam int LOGN = 512;
  // {length, seed, expected number of mailbox writes}
  localparam logic [23:0] VEC [10] = '{
    {8'd0,   8'h11, 8'd1},  {8'd1,   8'h22, 8'd2},  {8'd3,   8'h33, 8'd4},
    {8'd4,   8'h44, 8'd2},  {8'd5,   8'h55, 8'd3},  {8'd7,   8'h66, 8'd5},
    {8'd8,   8'h77, 8'd3},  {8'd64,  8'h88, 8'd17}, {8'd127, 8'h99, 8'd35},
    {8'd128, 8'hAA, 8'd33}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sub_valid = 1'b0;
  logic          sub_ready;
  logic [31:0]   sub_db = '0;
  logic [PW-1:0] sub_payload = '0;
  logic          mb_we, mb_doorbell;
  logic [6:0]    mb_addr;
  logic [31:0]   mb_wdata;
  logic [3:0]    mb_be;
  logic          clr_evt = 1'b0;
  logic          clr_ack, err_valid;
  logic [1:0]    err_code;

  int checks = 0, failures = 0;
  int ack_cnt = 0, err_cnt = 0;
  logic [1:0] last_err = 2'd0;
  bit finished = 1'b0;

  logic [31:0] lg_data [LOGN]; logic [3:0] lg_be [LOGN]; logic [6:0] lg_addr [LOGN]; logic lg_db [LOGN];
  logic [31:0] ex_data [LOGN]; logic [3:0] ex_be [LOGN]; logic [6:0] ex_addr [LOGN]; logic ex_db [LOGN];
  int lg_n = 0, ex_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbell_txq u_dut (
    .clk(clk), .rst(rst), .sub_valid(sub_valid), .sub_ready(sub_ready),
    .sub_db(sub_db), .sub_payload(sub_payload), .mb_we(mb_we),
    .mb_doorbell(mb_doorbell), .mb_addr(mb_addr), .mb_wdata(mb_wdata),
    .mb_be(mb_be), .clr_evt(clr_evt), .clr_ack(clr_ack),
    .err_valid(err_valid), .err_code(err_code)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (mb_we && lg_n < LOGN) begin
        lg_data[lg_n] = mb_wdata; lg_be[lg_n] = mb_be;
        lg_addr[lg_n] = mb_addr;  lg_db[lg_n] = mb_doorbell;
        lg_n++;
      end
      if (clr_ack) ack_cnt++;
      if (err_valid) begin err_cnt++; last_err = err_code; end
    end
  end

  function automatic logic [7:0] byte_of(input int seed, input int i);
    return 8'(seed * 37 + i * 13 + 5);
  endfunction

  function automatic logic [31:0] make_db(input int len, input int seed);
    return {1'b1, 11'd0, 4'(seed), 6'd0, 10'(len)};
  endfunction

  function automatic logic [PW-1:0] make_pay(input int seed);
    logic [PW-1:0] p;
    for (int i = 0; i < NB; i++) p[i*8 +: 8] = byte_of(seed, i);
    return p;
  endfunction

  task automatic push_exp(input logic [31:0] d, input logic [3:0] be, input logic [6:0] a, input logic db);
    if (ex_n < LOGN) begin
      ex_data[ex_n] = d; ex_be[ex_n] = be; ex_addr[ex_n] = a; ex_db[ex_n] = db; ex_n++;
    end
  endtask

  // Expected mailbox writes from R2/R3: words, then single bytes, then doorbell.
  task automatic add_msg(input int len, input int seed);
    int o = 0;
    while (len - o >= 4) begin
      push_exp({byte_of(seed, o+3), byte_of(seed, o+2), byte_of(seed, o+1), byte_of(seed, o)},
               4'hF, 7'(o), 1'b0);
      o += 4;
    end
    while (o < len) begin
      push_exp({4{byte_of(seed, o)}}, 4'b0001 << (o % 4), 7'(o), 1'b0);
      o++;
    end
    push_exp(make_db(len, seed), 4'hF, 7'd0, 1'b1);
  endtask

  task automatic chk(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_log(input string req);
    bit bad = 1'b0;
    int at = 0;
    chk(lg_n == ex_n, req, "write count", lg_n, ex_n);
    for (int i = 0; i < lg_n && i < ex_n; i++) begin
      if (!bad && (lg_data[i] !== ex_data[i] || lg_be[i] !== ex_be[i] ||
                   lg_addr[i] !== ex_addr[i] || lg_db[i] !== ex_db[i])) begin
        bad = 1'b1; at = i;
      end
    end
    chk(!bad, req, $sformatf("write content at %0d (be %0h/%0h addr %0d/%0d)",
        at, lg_be[at], ex_be[at], lg_addr[at], ex_addr[at]), lg_data[at], ex_data[at]);
    lg_n = 0; ex_n = 0;
  endtask

  task automatic submit(input int len, input int seed);
    @(negedge clk);
    sub_valid = 1'b1; sub_db = make_db(len, seed); sub_payload = make_pay(seed);
    #1;
    while (!sub_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    sub_valid = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_evt = 1'b1;
    @(negedge clk); clr_evt = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int mlen(input int i);
    return (i * 11 + 2) % 40;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int a0, e0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1
    chk(sub_ready == 1'b1, "R1", "ready after reset", sub_ready, 1);
    chk(!mb_we && !err_valid && !clr_ack, "R1", "quiet outputs", {mb_we, err_valid, clr_ack}, 0);

    // Table: idle-channel sends of many lengths (R2, R3, R11), then clear with empty queue (R9)
    for (int v = 0; v < 10; v++) begin
      int len, seed, nexp;
      len = int'(VEC[v][23:16]); seed = int'(VEC[v][15:8]); nexp = int'(VEC[v][7:0]);
      add_msg(len, seed);
      submit(len, seed);
      idle(45);
      chk(lg_n == nexp, (len == 0) ? "R11" : "R3", "writes for length", lg_n, nexp);
      compare_log((len == 0) ? "R11" : "R2");
      a0 = ack_cnt;
      pulse_clr();
      idle(4);
      chk(ack_cnt == a0 + 1, "R9", "ack after empty clear", ack_cnt, a0 + 1);
    end

    // R4 / R12: oversize rejected, channel stays idle
    e0 = err_cnt;
    submit(129, 3);
    idle(10);
    chk(err_cnt == e0 + 1, "R12", "one error pulse", err_cnt, e0 + 1);
    chk(last_err == 2'd1, "R4", "oversize code", last_err, 1);
    submit(1023, 4);
    idle(10);
    chk(err_cnt == e0 + 2 && last_err == 2'd1, "R4", "max field oversize", err_cnt, e0 + 2);
    chk(lg_n == 0, "R4", "nothing written", lg_n, 0);
    add_msg(8, 8'h40);
    submit(8, 8'h40);
    idle(20);
    compare_log("R4");
    pulse_clr(); idle(4);

    // R5 / R6: fill the queue behind one in flight
    e0 = err_cnt;
    add_msg(mlen(0), 8'h80 + 0);
    for (int i = 0; i < 9; i++) submit(mlen(i), 8'h80 + i);
    idle(45);
    chk(err_cnt == e0, "R5", "eight held without error", err_cnt, e0);
    submit(20, 8'hEE);
    idle(4);
    chk(err_cnt == e0 + 1 && last_err == 2'd2, "R6", "queue full code", last_err, 2);
    compare_log("R5");

    // R10: clear and submit in the same cycle while full; clear goes first
    a0 = ack_cnt;
    @(negedge clk);
    clr_evt = 1'b1; sub_valid = 1'b1;
    sub_db = make_db(mlen(9), 8'h89); sub_payload = make_pay(8'h89);
    #1;
    chk(sub_ready == 1'b0, "R10", "ready low during clear", sub_ready, 0);
    @(negedge clk); clr_evt = 1'b0;
    #1;
    while (!sub_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1; sub_valid = 1'b0;
    idle(45);
    chk(err_cnt == e0 + 1, "R10", "no error after clear-first order", err_cnt, e0 + 1);
    add_msg(mlen(1), 8'h81);
    compare_log("R7");

    // R7: remaining held messages leave in order
    for (int i = 2; i < 10; i++) begin
      add_msg(mlen(i), 8'h80 + i);
      pulse_clr();
      idle(45);
      compare_log("R7");
    end
    chk(ack_cnt == a0 + 9, "R9", "one ack per launching clear", ack_cnt, a0 + 9);

    // R8: clear with nothing held, then a direct send
    a0 = ack_cnt;
    pulse_clr(); idle(4);
    chk(ack_cnt == a0 + 1 && lg_n == 0, "R8", "idle after empty clear", ack_cnt, a0 + 1);
    add_msg(6, 8'h5A);
    submit(6, 8'h5A);
    idle(20);
    compare_log("R8");
    pulse_clr(); idle(4);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule